// File: doc/BRIEF.md
# Selectable Counter / PWM / LFSR Pattern Generator

This block produces an 8-bit pattern chosen from three internal sources: a free-running binary counter, a maximal-length linear feedback shift register (LFSR), and a pulse-width modulator that compares the counter against a threshold. A 2-bit mode field on the control input picks the source. A fourth mode forces the output low. The result is captured in an output register before it reaches the pins.

The block sits inside a fixed pin frame: an 8-bit control input, an 8-bit result output, and an 8-bit bidirectional group split into input, output and output-enable buses. The bidirectional group is used only as an input and carries the PWM threshold, so its output-enable and output buses are held at zero. A synchronous enable, driven by whatever selects this block among its neighbours, freezes the counter and LFSR and mutes the result. It acts on top of the asynchronous active-low reset.

There are no data streams here. Every pin is a plain level and is sampled on each clock edge, so there is no back-pressure to handle.

Top module: `patgen_top`

## Requirements
- R1: While `rst_n` is low, the counter is 0, the LFSR holds 8'h01 and `res_out` is 0.
- R2: At an edge where `en` is low, the counter and the LFSR keep their values, and `res_out` reads 0 after that edge whatever the mode.
- R3: Mode `ctl_in[1:0]` = 2'b00 puts the counter value on `res_out`. The counter rises by one at each enabled edge and wraps from 255 to 0.
- R4: Mode 2'b01 puts the LFSR on `res_out`. At each enabled edge the LFSR steps from q to {q[6:0], q[7]^q[5]^q[4]^q[3]}. It never reads zero and repeats every 255 enabled edges.
- R5: Mode 2'b10 drives all 8 bits of `res_out` high when the counter is below `io_in` and low otherwise. Over 256 enabled edges the high count equals the threshold, so threshold 0 gives constant low.
- R6: Mode 2'b11 drives `res_out` to 0.
- R7: `res_out` is registered. After an edge it shows the selection made from the mode and the state that held just before that edge, so a mode change appears one edge later.
- R8: `io_oe` and `io_out` are always 0, and `ctl_in[7:2]` has no effect on `res_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Synchronous enable; low freezes state and mutes the output |
| ctl_in | input | 8 | Control input; bits [1:0] select the mode, the other bits are unused |
| res_out | output | 8 | Registered pattern output |
| io_in | input | 8 | Bidirectional group, input side: PWM threshold |
| io_out | output | 8 | Bidirectional group, output side: held at 0 |
| io_oe | output | 8 | Bidirectional group, output enables: held at 0 (input only) |

## Verification
The bench builds the block with its default parameters: an 8-bit width, seed 8'h01 and a tap mask of 8'hB8. With these values the full 256-step counter wrap and the full 255-state LFSR cycle each fit in a few hundred cycles. That makes it possible to check the wrap, the return to the seed, PWM duty over whole periods at thresholds 0, 1, 128 and 255, and mutes inserted partway through a sequence.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef enum logic [1:0] {
    PG_COUNT = 2'b00,
    PG_LFSR  = 2'b01,
    PG_PWM   = 2'b10,
    PG_ZERO  = 2'b11
  } pg_mode_e;

  localparam int unsigned PG_MODE_W = 2;
endpackage

// File: rtl/pg_counter.sv
module pg_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (en) q <= q + ONE;
  end
endmodule

// File: rtl/pg_lfsr.sv
module pg_lfsr #(
  parameter int unsigned   W    = 8,
  parameter logic [W-1:0]  SEED = 8'h01,
  parameter logic [W-1:0]  TAPS = 8'hB8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  output logic [W-1:0] q
);
  logic [W-1:0] tapped;
  logic         fb;

  // Tap selection: one gate per bit, chosen by the mask parameter.
  for (genvar i = 0; i < W; i++) begin : g_tap
    if (TAPS[i]) begin : g_on
      assign tapped[i] = q[i];
    end else begin : g_off
      assign tapped[i] = 1'b0;
    end
  end

  assign fb = ^tapped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= SEED;
    else if (en) q <= {q[W-2:0], fb};
  end
endmodule

// File: rtl/pg_pwm.sv
module pg_pwm #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] thr,
  output logic [W-1:0] level
);
  logic hi;
  assign hi    = (cnt < thr);
  assign level = {W{hi}};
endmodule

// File: rtl/pg_outsel.sv
module pg_outsel
  import pg_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  pg_mode_e     mode,
  input  logic         en,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] lfsr,
  input  logic [W-1:0] pwm,
  output logic [W-1:0] nxt
);
  always_comb begin
    nxt = '0;
    if (en) begin
      unique case (mode)
        PG_COUNT: nxt = cnt;
        PG_LFSR:  nxt = lfsr;
        PG_PWM:   nxt = pwm;
        PG_ZERO:  nxt = '0;
        default:  nxt = '0;
      endcase
    end
  end
endmodule

// File: rtl/patgen_top.sv
module patgen_top
  import pg_pkg::*;
#(
  parameter int unsigned  W    = 8,
  parameter logic [W-1:0] SEED = 8'h01,
  parameter logic [W-1:0] TAPS = 8'hB8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] ctl_in,
  output logic [W-1:0] res_out,
  input  logic [W-1:0] io_in,
  output logic [W-1:0] io_out,
  output logic [W-1:0] io_oe
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] lfsr_q;
  logic [W-1:0] pwm_lvl;
  logic [W-1:0] res_nxt;
  pg_mode_e     mode;
  logic         unused_ctl;

  assign mode       = pg_mode_e'(ctl_in[PG_MODE_W-1:0]);
  assign unused_ctl = ^ctl_in[W-1:PG_MODE_W];

  pg_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en), .q(cnt_q)
  );

  pg_lfsr #(.W(W), .SEED(SEED), .TAPS(TAPS)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .en(en), .q(lfsr_q)
  );

  pg_pwm #(.W(W)) u_pwm (
    .cnt(cnt_q), .thr(io_in), .level(pwm_lvl)
  );

  pg_outsel #(.W(W)) u_sel (
    .mode(mode), .en(en), .cnt(cnt_q), .lfsr(lfsr_q), .pwm(pwm_lvl),
    .nxt(res_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_out <= '0;
    else res_out <= res_nxt;
  end

  assign io_out = '0;
  assign io_oe  = '0;
endmodule

// File: rtl/pg_checker.sv
module pg_checker #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic [1:0]   mode,
  input logic [W-1:0] cnt,
  input logic [W-1:0] lfsr,
  input logic [W-1:0] thr,
  input logic [W-1:0] res_out
);
  a_r2_mute: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> res_out == '0);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(cnt) && $stable(lfsr)));

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> cnt == W'($past(cnt) + 1'b1));

  a_r3_count_out: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == 2'b00) |=> res_out == $past(cnt));

  a_r4_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);

  a_r5_pwm_level: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == 2'b10) |=> res_out == {W{$past(cnt) < $past(thr)}});

  a_r6_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == 2'b11) |=> res_out == '0);
endmodule

bind patgen_top pg_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .mode(ctl_in[1:0]),
  .cnt(cnt_q), .lfsr(lfsr_q), .thr(io_in), .res_out(res_out)
);

// File: tb/sim_patgen_top.sv
`timescale 1ns/1ps
module sim_patgen_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] ctl_in = '0;
  logic [7:0] io_in = '0;
  logic [7:0] res_out, io_out, io_oe;

  int n_run = 0;
  int n_bad = 0;
  logic [7:0] m_cnt, m_lfsr, m_exp;

  always #5 clk = ~clk;

  patgen_top u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .ctl_in(ctl_in),
    .res_out(res_out), .io_in(io_in), .io_out(io_out), .io_oe(io_oe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // One clock: model the edge from the requirements, then compare at negedge.
  task automatic tick(input string tag);
    @(posedge clk);
    if (en) begin
      case (ctl_in[1:0])
        2'b00: m_exp = m_cnt;
        2'b01: m_exp = m_lfsr;
        2'b10: m_exp = (m_cnt < io_in) ? 8'hFF : 8'h00;
        default: m_exp = 8'h00;
      endcase
      m_cnt  = m_cnt + 8'd1;
      m_lfsr = {m_lfsr[6:0], m_lfsr[7] ^ m_lfsr[5] ^ m_lfsr[4] ^ m_lfsr[3]};
    end else begin
      m_exp = 8'h00;
    end
    @(negedge clk);
    chk(tag, res_out, m_exp);
    chk("R8 io_oe", io_oe, 8'h00);
    chk("R8 io_out", io_out, 8'h00);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; en = 1'b1; ctl_in = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 reset out", res_out, 8'h00);
    chk("R8 reset oe", io_oe, 8'h00);
    rst_n = 1'b1;
    m_cnt = 8'h00; m_lfsr = 8'h01;
    ctl_in = 8'h01;               // first LFSR output must be the seed
    tick("R1 seed");
    chk("R1 seed value", res_out, 8'h01);
    ctl_in = 8'h00;
    tick("R1 counter start");
    chk("R1 counter after one edge", res_out, 8'h01);
  endtask

  task automatic t_counter();
    ctl_in = 8'h00; en = 1'b1;
    for (int i = 0; i < 300; i++) tick("R3 counter");
  endtask

  task automatic t_lfsr();
    logic [7:0] first;
    ctl_in = 8'h01; en = 1'b1;
    tick("R4 lfsr");
    first = res_out;
    for (int i = 0; i < 254; i++) begin
      tick("R4 lfsr");
      if (res_out == first) chk("R4 early repeat", res_out, ~first);
      if (res_out == 8'h00) chk("R4 nonzero", res_out, 8'h01);
    end
    tick("R4 lfsr");
    chk("R4 period 255", res_out, first);
  endtask

  task automatic t_pwm(input logic [7:0] thr);
    int highs = 0;
    ctl_in = 8'h02; io_in = thr; en = 1'b1;
    tick("R5 pwm");             // settle one edge under the new threshold
    for (int i = 0; i < 256; i++) begin
      tick("R5 pwm");
      if (res_out == 8'hFF) highs++;
    end
    chk("R5 duty", 8'(highs), thr);
  endtask

  task automatic t_zero();
    ctl_in = 8'h03; en = 1'b1;
    for (int i = 0; i < 20; i++) tick("R6 zero mode");
  endtask

  task automatic t_mute();
    logic [7:0] held;
    en = 1'b1; ctl_in = 8'h00;
    for (int i = 0; i < 5; i++) tick("R2 pre");
    held = m_cnt;
    en = 1'b0;
    for (int m = 0; m < 4; m++) begin
      ctl_in = 8'(m);
      io_in = 8'hFF;
      for (int i = 0; i < 3; i++) tick("R2 muted");
    end
    en = 1'b1; ctl_in = 8'h00;
    tick("R2 resume");
    chk("R2 counter held", res_out, held);
  endtask

  task automatic t_mode_change();
    en = 1'b1; ctl_in = 8'h00;
    tick("R7 pre");
    ctl_in = 8'h03;
    chk("R7 unchanged before edge", res_out, m_exp);
    tick("R7 after edge");
    chk("R7 zero after one edge", res_out, 8'h00);
    ctl_in = 8'h00;
    tick("R7 back to counter");
  endtask

  task automatic t_ignore();
    en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      ctl_in = {6'(i * 7 + 13), 2'(i % 3)};
      io_in  = 8'(i * 37);
      tick("R8 upper ctl ignored");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_counter();
    t_lfsr();
    t_pwm(8'd0);
    t_pwm(8'd1);
    t_pwm(8'd128);
    t_pwm(8'd255);
    t_zero();
    t_mute();
    t_mode_change();
    t_ignore();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule